// File: doc/BRIEF.md
# Interrupt Request Priority Core

This block is the request-and-service core of a programmable interrupt controller. It has eight request lines. It holds one pending bit and one in-service bit for each line. Priority is fixed, and the line with the lowest index wins. The core raises a single interrupt output toward the processor only when an unmasked pending request outranks every line that is currently being serviced. The processor answers with two acknowledge pulses. The start of the first pulse moves the winning line from pending to in-service. During the second pulse the core drives the interrupt type, which is the base type plus the line index.

All lines share one trigger mode:
- **Edge mode.** A line is accepted only after it has been low for a set number of clock cycles. A line that stays high after service therefore raises nothing new.
- **Level mode.** A line that is still high when its service ends asks again at once.

A masked line still records its pending bit. It is simply not offered to the processor. A non-specific end-of-interrupt strobe retires the highest-priority in-service line. If the requesting line drops before the first acknowledge pulse, the core answers with the type of the lowest-priority line and leaves every in-service bit unchanged.

Top module: `irq_prio_core`

## Requirements
- R1: After reset, int_out and type_vld are 0, no line is pending or in service, and no line is armed in edge mode.
- R2: In edge mode (level_mode=0), a rising line is accepted only if it was sampled low on at least REARM_CYC consecutive clock edges just before. A line low for fewer edges, or held high after its service ends, raises nothing.
- R3: In level mode (level_mode=1), a line still high when its in-service bit is cleared by EOI is pending again one clock later, and int_out rises.
- R4: A masked line (mask_in bit = 1) still sets its pending bit, but int_out stays 0. Clearing the mask bit while the line is still high and pending makes int_out 1.
- R5: While a line's in-service bit is set, an assertion of that line is ignored. In edge mode that edge is consumed, so after EOI the line raises nothing until it rearms.
- R6: Priority is fixed, with line 0 highest. When several lines are pending, the first acknowledge takes the lowest index.
- R7: int_out is 1 only if some unmasked pending line has a lower index than every in-service line. A lower-priority request waits until EOI, and a higher-priority one interrupts a service already in progress.
- R8: The first clock that sees ack rise after idle clears the winner's pending bit and sets its in-service bit. From the clock that sees the second rise of ack until ack falls, type_vld=1 and type_out = base_type + index.
- R9: A one-cycle eoi pulse clears only the lowest-index in-service bit that is set.
- R10: If no line is eligible at the first acknowledge, the type returned is base_type + 7 and no in-service bit changes. A following request on line 7 is therefore still presented.
- R11: A line going low clears its pending bit in either mode, which drops int_out if it was the only request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_mode | input | 1 | 1 = level-sensitive lines, 0 = edge-sensitive |
| ir_in | input | 8 | Request lines, bit n = line n |
| mask_in | input | 8 | Mask bits, 1 hides line n from the processor |
| eoi | input | 1 | Non-specific end-of-interrupt strobe, one cycle |
| ack | input | 1 | Acknowledge pulses, active high, two per interrupt |
| base_type | input | 8 | Type of line 0 |
| int_out | output | 1 | Interrupt request to the processor |
| type_out | output | 8 | Interrupt type, valid with type_vld |
| type_vld | output | 1 | High during the second acknowledge pulse |

## Verification
Several behaviours are checked by assertions on every cycle:
- an edge-mode request only rises from an armed line;
- an in-service line never turns pending;
- at most one in-service bit is added per clock;
- an EOI removes exactly one in-service bit;
- a spurious acknowledge leaves the in-service state untouched;
- type_vld starts only inside an acknowledge pulse.

Other behaviours can only be shown by the bench scenarios, which compare the returned types against a queue of expected values:
- the rearm window boundary;
- the level-mode re-request after EOI;
- mask and unmask;
- priority order and nesting;
- the observable effect of a spurious cycle on line 7.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_GAP  = 2'd1,
    ACK_TYPE = 2'd2
  } ack_state_e;

endpackage

// File: rtl/irq_line_latch.sv
module irq_line_latch #(
  parameter int REARM_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ir,
  input  logic level_mode,
  input  logic in_srv,
  input  logic take,
  output logic req,
  output logic armed
);
  localparam int CNT_W = $clog2(REARM_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REARM_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             req_q, req_d;
  logic             set_req;

  always_comb begin
    if (ir)                  cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
    armed_d = ~ir & (armed_q | (cnt_d == CNT_MAX));
    set_req = ir & ~in_srv & (level_mode | armed_q);
    if (take)     req_d = 1'b0;
    else if (!ir) req_d = 1'b0;
    else          req_d = req_q | set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      req_q   <= req_d;
    end
  end

  assign req   = req_q;
  assign armed = armed_q;

  assert_edge_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && $rose(req_q)) |-> $past(armed_q));

  assert_srv_blocks_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_srv && !req_q) |=> !req_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0]         req,
  input  logic [NUM_LINES-1:0]         mask,
  input  logic [NUM_LINES-1:0]         isr,
  output logic [NUM_LINES-1:0]         win_oh,
  output logic [$clog2(NUM_LINES)-1:0] win_idx,
  output logic                         any
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] above_srv;
  logic [NUM_LINES-1:0] elig;

  always_comb begin
    // bits strictly below the lowest in-service bit; all ones when none in service
    above_srv = (isr & (~isr + 1'b1)) - 1'b1;
    elig      = req & ~mask & above_srv;
    win_oh    = elig & (~elig + 1'b1);
    any       = |elig;
    win_idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_prio_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TYPE_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ack,
  input  logic                         any,
  input  logic [$clog2(NUM_LINES)-1:0] win_idx,
  input  logic [TYPE_W-1:0]            base_type,
  output logic                         grab,
  output logic [TYPE_W-1:0]            type_out,
  output logic                         type_vld
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(NUM_LINES - 1);

  ack_state_e       st_q, st_d;
  logic             ack_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ack_rise;

  always_comb begin
    ack_rise = ack & ~ack_q;
    st_d     = st_q;
    idx_d    = idx_q;
    grab     = 1'b0;
    unique case (st_q)
      ACK_IDLE: if (ack_rise) begin
        grab  = 1'b1;
        idx_d = any ? win_idx : SPUR_IDX;
        st_d  = ACK_GAP;
      end
      ACK_GAP:  if (ack_rise) st_d = ACK_TYPE;
      ACK_TYPE: if (!ack)     st_d = ACK_IDLE;
      default:  st_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ACK_IDLE;
      ack_q <= 1'b0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack;
      idx_q <= idx_d;
    end
  end

  assign type_vld = (st_q == ACK_TYPE);
  assign type_out = base_type + TYPE_W'(idx_q);

  assert_type_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(type_vld) |-> ack);

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int NUM_LINES = 8,
  parameter int TYPE_W    = 8,
  parameter int REARM_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 level_mode,
  input  logic [NUM_LINES-1:0] ir_in,
  input  logic [NUM_LINES-1:0] mask_in,
  input  logic                 eoi,
  input  logic                 ack,
  input  logic [TYPE_W-1:0]    base_type,
  output logic                 int_out,
  output logic [TYPE_W-1:0]    type_out,
  output logic                 type_vld
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] req, armed, win_oh, take;
  logic [NUM_LINES-1:0] isr_q, isr_d, eoi_clr;
  logic [IDX_W-1:0]     win_idx;
  logic                 any, grab;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_line_latch #(.REARM_CYC(REARM_CYC)) line_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ir        (ir_in[g]),
      .level_mode(level_mode),
      .in_srv    (isr_q[g]),
      .take      (take[g]),
      .req       (req[g]),
      .armed     (armed[g])
    );
  end

  irq_prio_pick #(.NUM_LINES(NUM_LINES)) pick_i (
    .req    (req),
    .mask   (mask_in),
    .isr    (isr_q),
    .win_oh (win_oh),
    .win_idx(win_idx),
    .any    (any)
  );

  irq_ack_seq #(.NUM_LINES(NUM_LINES), .TYPE_W(TYPE_W)) ack_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .any      (any),
    .win_idx  (win_idx),
    .base_type(base_type),
    .grab     (grab),
    .type_out (type_out),
    .type_vld (type_vld)
  );

  always_comb begin
    take    = grab ? win_oh : '0;
    eoi_clr = eoi ? (isr_q & (~isr_q + 1'b1)) : '0;
    isr_d   = (isr_q & ~eoi_clr) | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assign int_out = any;

  assert_one_new_srv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr_q & ~$past(isr_q)) <= 1);

  assert_eoi_retires_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (isr_q != '0) && !grab) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  assert_spurious_keeps_srv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grab && !any && !eoi) |=> (isr_q == $past(isr_q)));

  assert_int_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((req & ~mask_in) != '0));

endmodule

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb_top;
  localparam int N    = 8;
  localparam int REARM = 3;
  localparam logic [7:0] BASE = 8'h60;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       level_mode;
  logic [7:0] ir_in, mask_in, base_type;
  logic       eoi, ack;
  logic       int_out, type_vld;
  logic [7:0] type_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  logic vld_prev = 1'b0;

  always #5 clk = ~clk;

  irq_prio_core #(.NUM_LINES(N), .TYPE_W(8), .REARM_CYC(REARM)) dut_i (
    .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .ir_in(ir_in),
    .mask_in(mask_in), .eoi(eoi), .ack(ack), .base_type(base_type),
    .int_out(int_out), .type_out(type_out), .type_vld(type_vld)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push expected type, then issue two acknowledge pulses
  task automatic do_ack(input int idx);
    exp_q.push_back(BASE + 8'(idx));
    ack = 1'b1; step(2);
    ack = 1'b0; step(2);
    ack = 1'b1; step(2);
    ack = 1'b0; step(1);
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1; step(1);
    eoi = 1'b0;
  endtask

  // monitor: compare each returned type against the queue
  always @(negedge clk) begin
    if (rst_n && type_vld && !vld_prev) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8: unexpected type %0h, expected none", type_out);
      end else begin
        chk(type_out, exp_q.pop_front(), "R8/R6/R10 returned type");
      end
    end
    vld_prev <= type_vld;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; level_mode = 1'b0; ir_in = '0; mask_in = '0;
    eoi = 1'b0; ack = 1'b0; base_type = BASE;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk({7'd0, int_out}, 8'd0, "R1 int_out after reset");
    chk({7'd0, type_vld}, 8'd0, "R1 type_vld after reset");
    ir_in[0] = 1'b1; step(1);
    chk({7'd0, int_out}, 8'd0, "R1 line not armed right after reset");
    ir_in[0] = 1'b0; step(6);

    // R2: edge acceptance and rearm window
    ir_in[3] = 1'b1; step(1);
    chk({7'd0, int_out}, 8'd1, "R2 armed edge raises int");
    do_ack(3);
    chk({7'd0, int_out}, 8'd0, "R8 int drops after acknowledge");
    pulse_eoi(); step(3);
    chk({7'd0, int_out}, 8'd0, "R2 held-high line after EOI");
    ir_in[3] = 1'b0; step(REARM - 1);
    ir_in[3] = 1'b1; step(2);
    chk({7'd0, int_out}, 8'd0, "R2 low too short does not rearm");
    ir_in[3] = 1'b0; step(REARM);
    ir_in[3] = 1'b1; step(1);
    chk({7'd0, int_out}, 8'd1, "R2 low for exactly the window rearms");
    do_ack(3); pulse_eoi(); ir_in[3] = 1'b0; step(1);

    // R3 and R11: level mode
    level_mode = 1'b1;
    ir_in[5] = 1'b1; step(1);
    chk({7'd0, int_out}, 8'd1, "R3 level line raises int");
    do_ack(5);
    chk({7'd0, int_out}, 8'd0, "R3 in-service level line blocked");
    pulse_eoi();
    chk({7'd0, int_out}, 8'd0, "R3 not yet pending on EOI edge");
    step(1);
    chk({7'd0, int_out}, 8'd1, "R3 re-request one clock after EOI");
    ir_in[5] = 1'b0; step(1);
    chk({7'd0, int_out}, 8'd0, "R11 line drop clears pending");
    level_mode = 1'b0; step(4);

    // R4: mask
    mask_in[2] = 1'b1; ir_in[2] = 1'b1; step(2);
    chk({7'd0, int_out}, 8'd0, "R4 masked line hidden");
    mask_in[2] = 1'b0; step(1);
    chk({7'd0, int_out}, 8'd1, "R4 unmask presents latched request");
    do_ack(2); pulse_eoi(); ir_in[2] = 1'b0; step(1);

    // R6, R7, R9: priority and nesting
    ir_in[1] = 1'b1; ir_in[4] = 1'b1; step(1);
    do_ack(1);
    chk({7'd0, int_out}, 8'd0, "R7 lower request waits for service");
    pulse_eoi(); step(1);
    chk({7'd0, int_out}, 8'd1, "R7 lower request after EOI");
    do_ack(4);
    ir_in[0] = 1'b1; step(1);
    chk({7'd0, int_out}, 8'd1, "R7 higher request nests");
    do_ack(0);
    pulse_eoi();
    ir_in[6] = 1'b1; step(1);
    chk({7'd0, int_out}, 8'd0, "R9 EOI kept line 4 in service");
    pulse_eoi(); step(1);
    chk({7'd0, int_out}, 8'd1, "R9 second EOI frees line 6");
    do_ack(6); pulse_eoi();
    ir_in = '0; step(5);

    // R5: assertion during service is ignored
    ir_in[3] = 1'b1; step(1);
    do_ack(3);
    ir_in[3] = 1'b0; step(REARM + 2);
    ir_in[3] = 1'b1; step(2);
    chk({7'd0, int_out}, 8'd0, "R5 in-service line ignored");
    ir_in[3] = 1'b0; step(1);
    pulse_eoi(); step(2);
    chk({7'd0, int_out}, 8'd0, "R5 ignored edge not replayed after EOI");

    // R10 / R11: spurious acknowledge
    ir_in[6] = 1'b1; step(1);
    chk({7'd0, int_out}, 8'd1, "R10 request raised");
    ir_in[6] = 1'b0; step(1);
    chk({7'd0, int_out}, 8'd0, "R11 withdrawn request drops int");
    do_ack(7);
    ir_in[7] = 1'b1; step(1);
    chk({7'd0, int_out}, 8'd1, "R10 spurious left line 7 out of service");
    do_ack(7); pulse_eoi(); ir_in[7] = 1'b0; step(3);

    chk(8'(exp_q.size()), 8'd0, "R8 all expected types returned");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule